// File: doc/BRIEF.md
# Unipolar Sine-Triangle Bridge Modulator

This block drives the four switches of a single-phase full bridge with unipolar sinusoidal pulse-width modulation. A triangular carrier and a sine reference are both read from small constant tables. A shared sample strobe advances both tables, and it is taken from the system clock by a clock-enable divider. The divider ratio and the carrier table length together set the switching frequency. The sine table is an integer number of carrier periods long, so that ratio sets the output frequency.

The modulation index arrives as an IEEE-754 single-precision word in the range 0 to 1. It is turned into an unsigned 8-bit amplitude code. The sine sample is scaled by this code and then placed about mid-scale twice: once with its own sign for leg A and once inverted for leg B. Each leg compares its reference with the carrier. The high-side gate of a leg is on while its reference is above the carrier, and the low-side gate is the complement. Because the two legs use opposite references, the bridge output switches between zero and one polarity. Its harmonics then sit around twice the switching frequency.

Top module: `spwm_bridge`

## Requirements
- R1: While reset is asserted, both high-side gates (gate_ap, gate_bp) are 0 and both low-side gates (gate_an, gate_bn) are 1.
- R2: A sample strobe fires once every DIV clocks. Each strobe advances the carrier address and the sine address by one. Between strobes both addresses hold.
- R3: The carrier table has CAR_LEN entries. With H = CAR_LEN/2, entry i is floor(255*d/H), where d = i for i < H and d = CAR_LEN - i otherwise. Its address wraps from CAR_LEN-1 to 0.
- R4: The sine table has SIN_LEN = CAR_LEN*SIN_MULT signed entries. With H = SIN_LEN/2, j = k mod H and u = j*(H-j), the magnitude is floor(2032*u/(5*H*H - 4*u)). It is positive for k < H and negated otherwise. Its address wraps on its own, so it always equals the carrier address modulo CAR_LEN.
- R5: A modulation word whose sign bit (bit 31) is set, or whose exponent field (bits 30:23) is 0, gives index code 0.
- R6: A non-negative word with an exponent field of 127 or more (value 1.0 or greater, including infinity) gives index code 255.
- R7: Any other word gives code floor(255 * (1 + mantissa/2^23) * 2^(exponent-127)).
- R8: With sine sample s and index code m, p = floor(s*m/256). Leg A uses reference 128 + p and leg B uses 128 - p.
- R9: gate_ap is 1 when leg A's reference is greater than the carrier sample, and gate_bp likewise for leg B. The gates update two clocks after the table address and the modulation word they depend on are presented.
- R10: gate_an is always the inverse of gate_ap, and gate_bn is always the inverse of gate_bp.
- R11: Whenever the index code in use is 0, gate_ap equals gate_bp, so the bridge output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_index | input | 32 | Modulation index, IEEE single precision |
| gate_ap | output | 1 | Leg A high-side switch |
| gate_an | output | 1 | Leg A low-side switch |
| gate_bp | output | 1 | Leg B high-side switch |
| gate_bn | output | 1 | Leg B low-side switch |

## Verification
A new modulation word can arrive on the very clock where the sample strobe moves both table addresses. The new index code and the new table samples then reach the comparators together. The stimulus holds each word for a different number of clocks, so changes fall on every phase of the divider, strobe edges included. The behavioural model in the bench updates the index and the samples in the same cycle, and it compares all four gates on every clock. This shows that no stale pairing of index and sample occurs.

// File: rtl/spwm_bridge.sv
module spwm_bridge #(
  parameter int DIV      = 4,
  parameter int CAR_LEN  = 4,
  parameter int SIN_MULT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] mod_index,
  output logic        gate_ap,
  output logic        gate_an,
  output logic        gate_bp,
  output logic        gate_bn
);
  localparam int SIN_LEN = CAR_LEN * SIN_MULT;
  localparam int CAW = $clog2(CAR_LEN);
  localparam int SAW = $clog2(SIN_LEN);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;

  function automatic int car_val(int i);
    int h, d;
    h = CAR_LEN / 2;
    d = (i < h) ? i : CAR_LEN - i;
    return (255 * d) / h;
  endfunction

  function automatic int sin_val(int k);
    int h, j, u, mag;
    h = SIN_LEN / 2;
    j = (k < h) ? k : k - h;
    u = j * (h - j);
    mag = (2032 * u) / (5 * h * h - 4 * u);
    return (k < h) ? mag : -mag;
  endfunction

  logic [7:0]        car_rom [CAR_LEN];
  logic signed [7:0] sin_rom [SIN_LEN];

  for (genvar g = 0; g < CAR_LEN; g++) begin : g_car
    assign car_rom[g] = 8'(car_val(g));
  end
  for (genvar g = 0; g < SIN_LEN; g++) begin : g_sin
    assign sin_rom[g] = 8'(sin_val(g));
  end

  logic [DCW-1:0] div_cnt;
  logic           tick;
  logic [CAW-1:0] car_addr;
  logic [SAW-1:0] sin_addr;

  assign tick = (div_cnt == DCW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      car_addr <= '0;
      sin_addr <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        car_addr <= (car_addr == CAW'(CAR_LEN - 1)) ? '0 : car_addr + 1'b1;
        sin_addr <= (sin_addr == SAW'(SIN_LEN - 1)) ? '0 : sin_addr + 1'b1;
      end
    end
  end

  logic [7:0]  exp_f;
  logic [31:0] sig_x255;
  logic [8:0]  shamt;
  logic [7:0]  m_code;

  assign exp_f    = mod_index[30:23];
  assign sig_x255 = {8'd0, 1'b1, mod_index[22:0]} * 32'd255;
  assign shamt    = 9'd150 - {1'b0, exp_f};

  always_comb begin
    if (mod_index[31] || exp_f == 8'd0) m_code = 8'd0;
    else if (exp_f >= 8'd127)           m_code = 8'd255;
    else if (shamt >= 9'd32)            m_code = 8'd0;
    else                                m_code = 8'(sig_x255 >> shamt[4:0]);
  end

  logic [7:0]        car_q;
  logic signed [7:0] sin_q;
  logic [7:0]        m_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= '0;
      sin_q <= '0;
      m_q   <= '0;
    end else begin
      car_q <= car_rom[car_addr];
      sin_q <= sin_rom[sin_addr];
      m_q   <= m_code;
    end
  end

  logic signed [16:0] prod_s;
  logic signed [8:0]  p_s;
  logic signed [9:0]  ref_a, ref_b, car_s;

  assign prod_s = 17'(sin_q) * $signed({9'd0, m_q});
  assign p_s    = prod_s[16:8];
  assign ref_a  = 10'sd128 + 10'(p_s);
  assign ref_b  = 10'sd128 - 10'(p_s);
  assign car_s  = $signed({2'b00, car_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_ap <= 1'b0;
      gate_an <= 1'b1;
      gate_bp <= 1'b0;
      gate_bn <= 1'b1;
    end else begin
      gate_ap <= ref_a >  car_s;
      gate_an <= ref_a <= car_s;
      gate_bp <= ref_b >  car_s;
      gate_bn <= ref_b <= car_s;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(car_addr) && $stable(sin_addr))); // R2
  AST_CAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && car_addr == CAW'(CAR_LEN - 1)) |=> (car_addr == '0)); // R3
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sin_addr) % CAR_LEN) == int'(car_addr)); // R4
  AST_NEG_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    mod_index[31] |=> (m_q == 8'd0)); // R5
  AST_FULL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_index[31] && mod_index[30:23] >= 8'd127) |=> (m_q == 8'd255)); // R6
  AST_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (m_q == 8'd0) |=> (gate_ap == gate_bp)); // R11
endmodule

// File: tb/sim_spwm_bridge.sv
module sim_spwm_bridge;
  localparam int DIV = 4, CAR_LEN = 4, SIN_MULT = 16;
  localparam int SIN_LEN = CAR_LEN * SIN_MULT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] mod_index = 32'd0;
  logic gate_ap, gate_an, gate_bp, gate_bn;
  int vecs = 0, errs = 0;
  bit running = 0, done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  spwm_bridge #(.DIV(DIV), .CAR_LEN(CAR_LEN), .SIN_MULT(SIN_MULT)) u0 (
    .clk(clk), .rst_n(rst_n), .mod_index(mod_index),
    .gate_ap(gate_ap), .gate_an(gate_an), .gate_bp(gate_bp), .gate_bn(gate_bn));

  // R3 carrier, R4 sine, R5-R7 index code, all from the requirement text
  function automatic int tri_at(int i);
    int h = CAR_LEN / 2;
    int d = (i < h) ? i : CAR_LEN - i;
    return (255 * d) / h;
  endfunction
  function automatic int sine_at(int k);
    int h = SIN_LEN / 2;
    int j = k % h;
    int u = j * (h - j);
    int mag = (2032 * u) / (5 * h * h - 4 * u);
    return (k < h) ? mag : -mag;
  endfunction
  function automatic int code_of(logic [31:0] f);
    int e = int'(f[30:23]);
    real v;
    if (f[31] || e == 0) return 0;
    if (e >= 127) return 255;
    v = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return int'($floor(255.0 * v));
  endfunction

  int cnt = 0, ca = 0, sa = 0, car_m = 0, sin_m = 0, m_m = 0, m_used = 0;
  bit e_ap = 0, e_bp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt = 0; ca = 0; sa = 0; car_m = 0; sin_m = 0; m_m = 0; m_used = 0;
      e_ap = 0; e_bp = 0;
    end else begin
      int p;
      p = (sin_m * m_m) >>> 8;                 // R8
      e_ap = (128 + p) > car_m;                // R9
      e_bp = (128 - p) > car_m;
      m_used = m_m;
      car_m = tri_at(ca);
      sin_m = sine_at(sa);
      m_m = code_of(mod_index);
      if (cnt == DIV - 1) begin                // R2
        cnt = 0;
        ca = (ca + 1) % CAR_LEN;
        sa = (sa + 1) % SIN_LEN;
      end else cnt++;
    end
  end

  task automatic chk(bit got, bit exp, string what);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s (%s): got %0b expected %0b at %0t", what, tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (running && rst_n && !done) begin
    chk(gate_ap, e_ap, "R9 gate_ap via R2 R3 R4 R8");
    chk(gate_bp, e_bp, "R9 gate_bp via R2 R3 R4 R8");
    chk(gate_an, !e_ap, "R10 gate_an");
    chk(gate_bn, !e_bp, "R10 gate_bn");
    if (m_used == 0) chk(gate_ap, gate_bp, "R11 zero index equal legs");
  end

  logic [31:0] words [12] = '{32'h3F000000, 32'h3F800000, 32'h3FC00000, 32'h7F800000,
                              32'h00000000, 32'hBF000000, 32'h00400000, 32'h3F400000,
                              32'h3DCCCCCD, 32'h33800000, 32'h3F7FBE77, 32'h3B808081};
  string tags [12] = '{"R7", "R6", "R6", "R6", "R5", "R5", "R5", "R7", "R7", "R7", "R7", "R7"};

  initial begin
    repeat (3) @(negedge clk);
    chk(gate_ap, 1'b0, "R1 gate_ap");
    chk(gate_an, 1'b1, "R1 gate_an");
    chk(gate_bp, 1'b0, "R1 gate_bp");
    chk(gate_bn, 1'b1, "R1 gate_bn");
    running = 1;
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tag = tags[i];
      mod_index = words[i];
      repeat (260 + 37 * i) @(negedge clk);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule